// File: doc/BRIEF.md
# Trap Entry and Vector Generator

This block performs the bookkeeping a processor core needs at the moment it takes a trap. A one-cycle request carries a 9-bit trap type together with the current program counter, next program counter, a state word, the two trap base addresses, a hypervisor-mode flag, the current window pointer and the can-save count. When the request is accepted, the block raises the trap level and records the state word, both program counters and the trap type in a small trap stack slot chosen by the new level. It then produces the fetch address of the handler and the address that follows it.

Close to the top of the level range, the block enters an error-recovery state. A request that arrives at the top of the range is not taken: it raises a fatal error flag and leaves every piece of state untouched. Clean-window, spill and fill traps also produce a new window pointer, computed modulo the number of register windows. Saved slots can be read back through a level-indexed read port as soon as the accepting clock edge has passed.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, trap_level is 0, and red_state, fatal_err, vec_valid and cwp_wr are all 0.
- R2: A request with trap_level below MAXTL-1 raises trap_level by exactly 1 and leaves red_state unchanged. trap_level never exceeds MAXTL.
- R3: A request with trap_level equal to MAXTL-1 raises trap_level to MAXTL and sets red_state. red_state then stays set until reset.
- R4: A request with trap_level at MAXTL or above sets fatal_err, which stays set until reset. trap_level is unchanged, vec_valid and cwp_wr stay 0, and no trap stack slot is written.
- R5: An accepted request writes the slot whose index is the low bits of the new trap level. The slot holds state_word, cur_pc, cur_npc and trap_type. It can be read on rd_state, rd_pc, rd_npc and rd_type through rd_level after the accepting edge. vec_valid pulses for one cycle after that edge.
- R6: With hyp_mode low, vec_pc is tbr with bits 14:0 cleared, ORed with bit 14 set when the new level is greater than 1, ORed with trap_type in bits 13:5.
- R7: With hyp_mode high, vec_pc is htba with bits 13:0 cleared, ORed with trap_type in bits 13:5.
- R8: vec_npc equals vec_pc plus 4.
- R9: A trap type with (type & 0x1C0) == 0x080 is a spill. It pulses cwp_wr with cwp_new = (cwp - cansave - 2) mod NWIN.
- R10: A trap type with (type & 0x1C0) == 0x0C0 is a fill. It pulses cwp_wr with cwp_new = (cwp + 1) mod NWIN.
- R11: Trap type 0x024 is a clean-window trap. It pulses cwp_wr with cwp_new = (cwp - 1) mod NWIN.
- R12: Any other trap type leaves cwp_wr at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_type | input | 9 | Trap type of the request |
| cur_pc | input | PCW | Program counter to save |
| cur_npc | input | PCW | Next program counter to save |
| state_word | input | SW | State word to save |
| tbr | input | PCW | Trap base for normal mode |
| htba | input | PCW | Trap base for hypervisor mode |
| hyp_mode | input | 1 | Selects the hypervisor vector form |
| cwp | input | CWPW | Current window pointer |
| cansave | input | CWPW | Can-save window count |
| rd_level | input | IW | Trap stack read index |
| trap_level | output | TLW | Current trap level |
| red_state | output | 1 | Error-recovery state flag |
| fatal_err | output | 1 | Trap taken at maximum level |
| vec_valid | output | 1 | Vector outputs valid (one cycle) |
| vec_pc | output | PCW | Handler fetch address |
| vec_npc | output | PCW | Address after the handler fetch address |
| cwp_wr | output | 1 | Window pointer update strobe |
| cwp_new | output | CWPW | New window pointer |
| rd_state | output | SW | Saved state word at rd_level |
| rd_pc | output | PCW | Saved PC at rd_level |
| rd_npc | output | PCW | Saved NPC at rd_level |
| rd_type | output | 9 | Saved trap type at rd_level |

## Verification
A run of requests climbs the trap level from zero to the top of the range. Along the way it crosses the error-recovery boundary and then tries one request past the limit. This separates a plain increment from the recovery entry and from a refused trap that must leave the stack intact. Normal and hypervisor requests alternate over a trap base whose low bits are all ones, which shows whether the right bits are cleared and whether the level-dependent bit 14 follows the new level. Clean, spill, fill and unclassified trap types are given window pointers and can-save counts that wrap past both ends of the window range, so an error in the modular arithmetic shows up. A final reset followed by a request confirms that the recovery and fatal flags clear.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam logic [8:0] TT_CLEAN_WIN = 9'h024;
  localparam logic [8:0] TT_CLASS_MSK = 9'h1C0;
  localparam logic [8:0] TT_SPILL_CLS = 9'h080;
  localparam logic [8:0] TT_FILL_CLS  = 9'h0C0;

  typedef enum logic [1:0] {
    WADJ_NONE  = 2'd0,
    WADJ_CLEAN = 2'd1,
    WADJ_SPILL = 2'd2,
    WADJ_FILL  = 2'd3
  } win_adj_e;

  function automatic win_adj_e classify_window(input logic [8:0] tt);
    win_adj_e k;
    if (tt == TT_CLEAN_WIN)                          k = WADJ_CLEAN;
    else if ((tt & TT_CLASS_MSK) == TT_SPILL_CLS)    k = WADJ_SPILL;
    else if ((tt & TT_CLASS_MSK) == TT_FILL_CLS)     k = WADJ_FILL;
    else                                             k = WADJ_NONE;
    return k;
  endfunction

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
  parameter int MAXTL = 6,
  parameter int TLW   = $clog2(MAXTL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trap_req,
  output logic [TLW-1:0] level_q,
  output logic [TLW-1:0] level_next,
  output logic           red_q,
  output logic           fatal_q,
  output logic           accept
);
  localparam logic [TLW-1:0] LMAX  = TLW'(MAXTL);
  localparam logic [TLW-1:0] LMAX1 = TLW'(MAXTL - 1);

  logic [TLW-1:0] level_d;
  logic           red_d, fatal_d, upd_en;

  assign accept     = trap_req && (level_q < LMAX);
  assign level_next = level_q + TLW'(1);
  assign upd_en     = trap_req;

  always_comb begin
    level_d = level_q;
    red_d   = red_q;
    fatal_d = fatal_q;
    if (trap_req) begin
      if (level_q >= LMAX) begin
        fatal_d = 1'b1;
      end else begin
        level_d = level_next;
        if (level_q >= LMAX1) red_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      red_q   <= 1'b0;
      fatal_q <= 1'b0;
    end else if (upd_en) begin
      level_q <= level_d;
      red_q   <= red_d;
      fatal_q <= fatal_d;
    end
  end
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
  parameter int PCW = 32,
  parameter int TLW = 3
) (
  input  logic [8:0]     tt,
  input  logic [TLW-1:0] new_level,
  input  logic [PCW-1:0] tbr,
  input  logic [PCW-1:0] htba,
  input  logic           hyp,
  output logic [PCW-1:0] pc,
  output logic [PCW-1:0] npc
);
  localparam logic [PCW-1:0] NORM_MSK = PCW'(15'h7FFF);
  localparam logic [PCW-1:0] HYP_MSK  = PCW'(14'h3FFF);
  localparam logic [PCW-1:0] LVL_BIT  = PCW'(15'h4000);

  logic [PCW-1:0] type_off;

  always_comb begin
    type_off = PCW'({tt, 5'b00000});
    if (hyp) begin
      pc = (htba & ~HYP_MSK) | type_off;
    end else begin
      pc = (tbr & ~NORM_MSK) | type_off;
      if (new_level > TLW'(1)) pc = pc | LVL_BIT;
    end
    npc = pc + PCW'(4);
  end
endmodule

// File: rtl/trap_window_adj.sv
module trap_window_adj
  import trap_entry_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CWPW = $clog2(NWIN)
) (
  input  logic [8:0]      tt,
  input  logic [CWPW-1:0] cwp,
  input  logic [CWPW-1:0] cansave,
  output logic            adj_en,
  output logic [CWPW-1:0] cwp_adj
);
  win_adj_e kind;
  int       cur, cs, res;

  always_comb begin
    kind = classify_window(tt);
    cur  = int'(cwp);
    cs   = int'(cansave);
    unique case (kind)
      WADJ_CLEAN: res = (cur + 2*NWIN - 1) % NWIN;
      WADJ_SPILL: res = (cur + 2*NWIN - cs - 2) % NWIN;
      WADJ_FILL:  res = (cur + 1) % NWIN;
      default:    res = cur;
    endcase
    adj_en  = (kind != WADJ_NONE);
    cwp_adj = CWPW'(res);
  end
endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH),
  parameter int PCW   = 32,
  parameter int SW    = 8
) (
  input  logic           clk,
  input  logic           we,
  input  logic [IW-1:0]  wr_idx,
  input  logic [SW-1:0]  wr_state,
  input  logic [PCW-1:0] wr_pc,
  input  logic [PCW-1:0] wr_npc,
  input  logic [8:0]     wr_type,
  input  logic [IW-1:0]  rd_idx,
  output logic [SW-1:0]  rd_state,
  output logic [PCW-1:0] rd_pc,
  output logic [PCW-1:0] rd_npc,
  output logic [8:0]     rd_type
);
  localparam int EW = SW + 2*PCW + 9;

  logic [EW-1:0] slot [DEPTH];
  logic [EW-1:0] rd_word;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot[g] <= {wr_state, wr_pc, wr_npc, wr_type};
    end
  end

  assign rd_word = slot[rd_idx];
  assign {rd_state, rd_pc, rd_npc, rd_type} = rd_word;
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int MAXTL  = 6,
  parameter int SDEPTH = 8,
  parameter int NWIN   = 8,
  parameter int PCW    = 32,
  parameter int SW     = 8,
  parameter int TLW    = $clog2(MAXTL + 1),
  parameter int IW     = $clog2(SDEPTH),
  parameter int CWPW   = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic [8:0]      trap_type,
  input  logic [PCW-1:0]  cur_pc,
  input  logic [PCW-1:0]  cur_npc,
  input  logic [SW-1:0]   state_word,
  input  logic [PCW-1:0]  tbr,
  input  logic [PCW-1:0]  htba,
  input  logic            hyp_mode,
  input  logic [CWPW-1:0] cwp,
  input  logic [CWPW-1:0] cansave,
  input  logic [IW-1:0]   rd_level,
  output logic [TLW-1:0]  trap_level,
  output logic            red_state,
  output logic            fatal_err,
  output logic            vec_valid,
  output logic [PCW-1:0]  vec_pc,
  output logic [PCW-1:0]  vec_npc,
  output logic            cwp_wr,
  output logic [CWPW-1:0] cwp_new,
  output logic [SW-1:0]   rd_state,
  output logic [PCW-1:0]  rd_pc,
  output logic [PCW-1:0]  rd_npc,
  output logic [8:0]      rd_type
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [TLW-1:0]  lvl_next;
  logic            accept;
  logic [PCW-1:0]  calc_pc, calc_npc;
  logic            adj_en;
  logic [CWPW-1:0] cwp_adj;

  trap_level_ctl #(.MAXTL(MAXTL), .TLW(TLW)) u_level (
    .clk(clk), .rst_n(rst_sync_n), .trap_req(trap_req),
    .level_q(trap_level), .level_next(lvl_next),
    .red_q(red_state), .fatal_q(fatal_err), .accept(accept)
  );

  trap_vector_calc #(.PCW(PCW), .TLW(TLW)) u_vec (
    .tt(trap_type), .new_level(lvl_next), .tbr(tbr), .htba(htba),
    .hyp(hyp_mode), .pc(calc_pc), .npc(calc_npc)
  );

  trap_window_adj #(.NWIN(NWIN), .CWPW(CWPW)) u_win (
    .tt(trap_type), .cwp(cwp), .cansave(cansave),
    .adj_en(adj_en), .cwp_adj(cwp_adj)
  );

  trap_stack #(.DEPTH(SDEPTH), .IW(IW), .PCW(PCW), .SW(SW)) u_stack (
    .clk(clk), .we(accept), .wr_idx(IW'(lvl_next)),
    .wr_state(state_word), .wr_pc(cur_pc), .wr_npc(cur_npc),
    .wr_type(trap_type), .rd_idx(rd_level),
    .rd_state(rd_state), .rd_pc(rd_pc), .rd_npc(rd_npc), .rd_type(rd_type)
  );

  // output stage: strobes every cycle, data only on acceptance
  logic vec_valid_d, cwp_wr_d, data_en;

  always_comb begin
    vec_valid_d = accept;
    cwp_wr_d    = accept && adj_en;
    data_en     = accept;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_valid <= 1'b0;
      cwp_wr    <= 1'b0;
    end else begin
      vec_valid <= vec_valid_d;
      cwp_wr    <= cwp_wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_pc  <= '0;
      vec_npc <= '0;
      cwp_new <= '0;
    end else if (data_en) begin
      vec_pc  <= calc_pc;
      vec_npc <= calc_npc;
      cwp_new <= cwp_adj;
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int MAXTL = 6,
  parameter int PCW   = 32,
  parameter int TLW   = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trap_req,
  input logic [8:0]     trap_type,
  input logic [TLW-1:0] trap_level,
  input logic           red_state,
  input logic           fatal_err,
  input logic           vec_valid,
  input logic [PCW-1:0] vec_pc,
  input logic [PCW-1:0] vec_npc,
  input logic           cwp_wr
);
  localparam logic [TLW-1:0] LMAX  = TLW'(MAXTL);
  localparam logic [TLW-1:0] LMAX1 = TLW'(MAXTL - 1);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_level <= LMAX);

  p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_level < LMAX1) |=>
      (trap_level == $past(trap_level) + TLW'(1)) && (red_state == $past(red_state)));

  p_red_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_level == LMAX1) |=> (red_state && trap_level == LMAX));

  p_red_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    red_state |=> red_state);

  p_fatal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_level >= LMAX) |=>
      (fatal_err && !vec_valid && !cwp_wr && $stable(trap_level)));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(trap_req));

  p_type_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_pc[4:0] == 5'd0 && vec_pc[13:5] == $past(trap_type)));

  p_npc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_npc - vec_pc == PCW'(4)));

  p_cwp_with_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_wr |-> vec_valid);
endmodule

bind trap_entry_unit trap_entry_chk #(.MAXTL(MAXTL), .PCW(PCW), .TLW(TLW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .trap_req(trap_req), .trap_type(trap_type),
  .trap_level(trap_level), .red_state(red_state), .fatal_err(fatal_err),
  .vec_valid(vec_valid), .vec_pc(vec_pc), .vec_npc(vec_npc), .cwp_wr(cwp_wr)
);

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;
  localparam int MAXTL = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_req;
  logic [8:0]  trap_type;
  logic [31:0] cur_pc, cur_npc, tbr, htba;
  logic [7:0]  state_word;
  logic        hyp_mode;
  logic [2:0]  cwp, cansave, rd_level;
  logic [2:0]  trap_level;
  logic        red_state, fatal_err, vec_valid, cwp_wr;
  logic [31:0] vec_pc, vec_npc;
  logic [2:0]  cwp_new;
  logic [7:0]  rd_state;
  logic [31:0] rd_pc, rd_npc;
  logic [8:0]  rd_type;

  trap_entry_unit uut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .state_word(state_word), .tbr(tbr),
    .htba(htba), .hyp_mode(hyp_mode), .cwp(cwp), .cansave(cansave),
    .rd_level(rd_level), .trap_level(trap_level), .red_state(red_state),
    .fatal_err(fatal_err), .vec_valid(vec_valid), .vec_pc(vec_pc),
    .vec_npc(vec_npc), .cwp_wr(cwp_wr), .cwp_new(cwp_new),
    .rd_state(rd_state), .rd_pc(rd_pc), .rd_npc(rd_npc), .rd_type(rd_type)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] npc;
    logic        wr;
    logic [2:0]  cw;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  // bench model
  int          m_tl;
  logic        m_red, m_fatal;
  logic [7:0]  m_st  [8];
  logic [31:0] m_pc  [8];
  logic [31:0] m_npc [8];
  logic [8:0]  m_tt  [8];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wrap8(input int x);
    return ((x % 8) + 8) % 8;
  endfunction

  // monitor: pops the scoreboard on every vector strobe
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected vector", 64'(vec_pc), 64'hDEAD);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " vec_pc"}, 64'(vec_pc), 64'(e.pc));
        check("R8 vec_npc", 64'(vec_npc), 64'(e.npc));
        check({e.tag, " cwp_wr"}, 64'(cwp_wr), 64'(e.wr));
        if (e.wr) check({e.tag, " cwp_new"}, 64'(cwp_new), 64'(e.cw));
      end
    end else if (rst_n && cwp_wr) begin
      check("R12 cwp_wr without vector", 64'(cwp_wr), 64'd0);
    end
  end

  task automatic do_trap(input logic [8:0] tt, input logic hyp,
                         input logic [2:0] w, input logic [2:0] cs,
                         input string wtag);
    exp_t e;
    logic [31:0] p;
    int nt;
    logic [31:0] pcv, npcv;
    logic [7:0]  stv;
    pcv  = 32'h4000_0000 + 32'(tt) * 16;
    npcv = pcv + 4;
    stv  = 8'(tt) ^ 8'h5A;
    if (m_tl >= MAXTL) begin
      m_fatal = 1'b1;
    end else begin
      if (m_tl >= MAXTL - 1) m_red = 1'b1;
      nt = m_tl + 1;
      if (hyp) p = (32'h1234_5FFF & ~32'h3FFF) | (32'(tt) << 5);
      else     p = (32'hABCD_FFFF & ~32'h7FFF) | (nt > 1 ? 32'h4000 : 32'h0) | (32'(tt) << 5);
      e.pc  = p;
      e.npc = p + 4;
      e.tag = hyp ? "R7" : "R6";
      if (tt == 9'h024)                       begin e.wr = 1; e.cw = 3'(wrap8(int'(w) - 1)); end
      else if ((tt & 9'h1C0) == 9'h080)       begin e.wr = 1; e.cw = 3'(wrap8(int'(w) - int'(cs) - 2)); end
      else if ((tt & 9'h1C0) == 9'h0C0)       begin e.wr = 1; e.cw = 3'(wrap8(int'(w) + 1)); end
      else                                    begin e.wr = 0; e.cw = 3'd0; end
      if (e.wr == 0) e.tag = {e.tag, "/R12"}; else e.tag = {e.tag, "/", wtag};
      exp_q.push_back(e);
      m_tl = nt;
      m_st[nt % 8] = stv; m_pc[nt % 8] = pcv; m_npc[nt % 8] = npcv; m_tt[nt % 8] = tt;
    end
    trap_type = tt; hyp_mode = hyp; cwp = w; cansave = cs;
    cur_pc = pcv; cur_npc = npcv; state_word = stv;
    trap_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trap_req = 1'b0;
    // state after the accepting edge
    check("R2 trap_level", 64'(trap_level), 64'(m_tl));
    check("R3 red_state", 64'(red_state), 64'(m_red));
    check("R4 fatal_err", 64'(fatal_err), 64'(m_fatal));
    rd_level = 3'(m_tl);
    #1;
    check("R5 rd_state", 64'(rd_state), 64'(m_st[m_tl % 8]));
    check("R5 rd_pc", 64'(rd_pc), 64'(m_pc[m_tl % 8]));
    check("R5 rd_npc", 64'(rd_npc), 64'(m_npc[m_tl % 8]));
    check("R5 rd_type", 64'(rd_type), 64'(m_tt[m_tl % 8]));
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_tl = 0; m_red = 1'b0; m_fatal = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 trap_level", 64'(trap_level), 64'd0);
    check("R1 red_state", 64'(red_state), 64'd0);
    check("R1 fatal_err", 64'(fatal_err), 64'd0);
    check("R1 vec_valid", 64'(vec_valid), 64'd0);
    check("R1 cwp_wr", 64'(cwp_wr), 64'd0);
  endtask

  initial begin
    trap_req = 0; trap_type = 0; cur_pc = 0; cur_npc = 0; state_word = 0;
    tbr = 32'hABCD_FFFF; htba = 32'h1234_5FFF; hyp_mode = 0;
    cwp = 0; cansave = 0; rd_level = 0;
    @(negedge clk);
    do_reset();
    do_trap(9'h024, 1'b0, 3'd0, 3'd0, "R11");   // clean, wraps 0 -> 7, level 1
    do_trap(9'h085, 1'b0, 3'd1, 3'd2, "R9");    // spill, 1-2-2 -> 5, bit 14
    do_trap(9'h0C3, 1'b1, 3'd7, 3'd0, "R10");   // fill, 7 -> 0, hypervisor
    do_trap(9'h041, 1'b0, 3'd3, 3'd1, "R12");   // unclassified
    do_trap(9'h1FF, 1'b1, 3'd4, 3'd0, "R12");   // highest type
    do_trap(9'h0BF, 1'b0, 3'd0, 3'd7, "R9");    // spill 0-7-2 -> 7, enters red (R3)
    do_trap(9'h010, 1'b0, 3'd2, 3'd0, "R4");    // refused: fatal (R4)
    // R4: refused request left the top slot as it was
    rd_level = 3'(MAXTL);
    #1;
    check("R4 slot kept pc", 64'(rd_pc), 64'(m_pc[MAXTL]));
    check("R4 slot kept type", 64'(rd_type), 64'(m_tt[MAXTL]));
    do_reset();
    do_trap(9'h0C0, 1'b0, 3'd6, 3'd0, "R10");   // after reset: red clear, level 1
    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule